// File: doc/BRIEF.md
# Character Display Host Bus Port

This block sits between a host processor and the core of a character display controller. The host uses an asynchronous strobe bus. A strobe `hb_e` frames each transfer. A select `hb_rs` picks either the command path or the data path. A direction `hb_rw` picks read or write, and an 8-bit data bus carries the byte. The block brings the strobe into the core clock domain through a synchronizer. It captures the bus lines while the strobe is high and completes the transfer when the strobe falls.

When the strobe falls, a write is turned into a one-cycle command strobe or a one-cycle data-write strobe toward the core. A data read is turned into a one-cycle read-request strobe, which asks the core to advance its address and refill the data register. A status read returns the core's busy flag on bit 7 and the address counter on bits 6..0. A data read returns the data register. The core keeps that register loaded ahead of time through a fill port.

Any completed access other than a status read is dropped while the core reports busy. A narrow mode carries each byte as two transfers on the upper four lines, high nibble first.

The strobes toward the core have no back-pressure. Each one is valid for exactly one clock, and the core must take it in that cycle. The fill port has no ready signal either: a fill is accepted on every cycle in which it is valid.

Top module: `lcd_host_port`

## Requirements
- R1: `hb_d_oe` is 1 exactly while `hb_e`=1 and `hb_rw`=1, and is 0 otherwise. This includes the idle state after reset.
- R2: In 8-bit mode, a read with `hb_rs`=0 drives `{core_busy, core_addr[6:0]}` on `hb_d_out`, with the busy flag on bit 7.
- R3: A read with `hb_rs`=1 drives the data register. The data register is 0 after reset and loads `fill_byte` on every cycle in which `fill_valid`=1.
- R4: A completed write with `hb_rs`=0 while `core_busy`=0 raises `cmd_valid` for one cycle with the written byte on `cmd_byte`. The strobe appears on the 4th rising clock edge that samples `hb_e` low.
- R5: A completed write with `hb_rs`=1 while `core_busy`=0 raises `wr_valid` for one cycle with the written byte on `wr_byte`, with the same latency as R4.
- R6: While `core_busy`=1, a completed command write, data write or data read raises none of `cmd_valid`, `wr_valid` or `rd_req`.
- R7: A completed read with `hb_rs`=1 while `core_busy`=0 raises `rd_req` for one cycle, with the same latency as R4.
- R8: With `nib_mode`=1, only `hb_d_in[7:4]` carries data and the high nibble is sent first. A byte is complete only after the second transfer. Reads drive the high nibble and then the low nibble on `hb_d_out[7:4]`, with `hb_d_out[3:0]`=0.
- R9: Both reset and any change of `nib_mode` return the nibble phase to "high nibble next". After reset, `cmd_valid`, `wr_valid` and `rd_req` are 0.
- R10: A status read is served while `core_busy`=1 and raises no strobe toward the core.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low synchronous reset |
| nib_mode | input | 1 | 1 selects the two-transfer 4-bit bus mode |
| hb_e | input | 1 | Host transfer strobe; completes on its falling edge |
| hb_rs | input | 1 | 0 selects command/status, 1 selects data |
| hb_rw | input | 1 | 1 read, 0 write |
| hb_d_in | input | 8 | Host data bus, input side |
| hb_d_out | output | 8 | Host data bus, output side |
| hb_d_oe | output | 1 | Output enable for the host data bus |
| core_busy | input | 1 | Busy flag from the core |
| core_addr | input | 7 | Address counter from the core |
| fill_valid | input | 1 | Load the data register with `fill_byte` |
| fill_byte | input | 8 | Prefetched RAM byte |
| cmd_valid | output | 1 | One-cycle command strobe |
| cmd_byte | output | 8 | Command byte |
| wr_valid | output | 1 | One-cycle data-write strobe |
| wr_byte | output | 8 | Data byte to write |
| rd_req | output | 1 | One-cycle request to advance and refill after a data read |

## Verification
Read data and the output enable follow the bus pins within the same cycle. The bench therefore samples them one clock after raising the strobe, while the strobe is still high. The core strobes appear on the 4th rising edge after the dropped strobe is first sampled: three stages come from synchronizing and detecting the edge, and one from issuing the strobe. Each scenario task samples the strobes at the falling clock edge right after that rising edge, and again one cycle later to confirm the pulse is single. The nibble phase is re-armed one cycle after a mode change, so the bench waits two cycles after switching modes before it starts a new transfer.

// File: rtl/lcd_hbi_pkg.sv
package lcd_hbi_pkg;
  localparam int BYTE_W = 8;
  localparam int NIB_W  = BYTE_W / 2;
  localparam int ADDR_W = BYTE_W - 1;

  typedef struct packed {
    logic              rs;
    logic              rw;
    logic [BYTE_W-1:0] d;
  } hb_xfer_t;
endpackage

// File: rtl/hbi_strobe_sync.sv
module hbi_strobe_sync
  import lcd_hbi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic     clk,
  input  logic     rst_n,
  input  logic     e_raw,
  input  hb_xfer_t bus_raw,
  output logic     fall,
  output hb_xfer_t cap
);
  localparam int CHAIN_W = SYNC_STAGES + 1;

  logic [CHAIN_W-1:0] chain_q;
  logic               e_high;

  assign e_high = chain_q[SYNC_STAGES-1];
  assign fall   = chain_q[SYNC_STAGES] & ~e_high;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      chain_q <= '0;
      cap     <= '0;
    end else begin
      chain_q <= {chain_q[CHAIN_W-2:0], e_raw};
      if (e_high) cap <= bus_raw;
    end
  end

  // R4: an edge pulse never lasts two cycles
  AST_FALL_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    fall |=> !fall); // R4
endmodule

// File: rtl/hbi_nibble_pack.sv
module hbi_nibble_pack
  import lcd_hbi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     nib_mode,
  input  logic     fall,
  input  hb_xfer_t cap,
  output logic     byte_valid,
  output hb_xfer_t byte_x,
  output logic     phase
);
  logic             mode_q;
  logic [NIB_W-1:0] hi_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q     <= 1'b0;
      phase      <= 1'b0;
      hi_q       <= '0;
      byte_valid <= 1'b0;
      byte_x     <= '0;
    end else begin
      mode_q     <= nib_mode;
      byte_valid <= 1'b0;
      if (mode_q != nib_mode) begin
        phase <= 1'b0;
      end else if (fall) begin
        if (!nib_mode) begin
          byte_valid <= 1'b1;
          byte_x     <= cap;
        end else if (!phase) begin
          hi_q  <= cap.d[BYTE_W-1:NIB_W];
          phase <= 1'b1;
        end else begin
          byte_valid <= 1'b1;
          byte_x     <= '{rs: cap.rs, rw: cap.rw, d: {hi_q, cap.d[BYTE_W-1:NIB_W]}};
          phase      <= 1'b0;
        end
      end
    end
  end

  AST_MODE_REARM: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q != nib_mode) |=> !phase); // R9
  AST_WIDE_EVERY_FALL: assert property (@(posedge clk) disable iff (!rst_n)
    (fall && !nib_mode && mode_q == nib_mode) |=> byte_valid); // R8
endmodule

// File: rtl/hbi_core_gate.sv
module hbi_core_gate
  import lcd_hbi_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              byte_valid,
  input  hb_xfer_t          byte_x,
  input  logic              busy,
  input  logic              fill_valid,
  input  logic [BYTE_W-1:0] fill_byte,
  output logic [BYTE_W-1:0] data_q,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              rd_req
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      data_q    <= '0;
      cmd_valid <= 1'b0;
      cmd_byte  <= '0;
      wr_valid  <= 1'b0;
      wr_byte   <= '0;
      rd_req    <= 1'b0;
    end else begin
      cmd_valid <= 1'b0;
      wr_valid  <= 1'b0;
      rd_req    <= 1'b0;
      if (fill_valid) data_q <= fill_byte;
      if (byte_valid && !busy) begin
        unique case ({byte_x.rs, byte_x.rw})
          2'b00: begin cmd_valid <= 1'b1; cmd_byte <= byte_x.d; end
          2'b10: begin wr_valid  <= 1'b1; wr_byte  <= byte_x.d; end
          2'b11: rd_req <= 1'b1;
          default: ;
        endcase
      end
    end
  end

  AST_BUSY_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && busy) |=> !(cmd_valid || wr_valid || rd_req)); // R6
  AST_ONE_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_valid, wr_valid, rd_req})); // R5
  AST_STATUS_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
    (byte_valid && !byte_x.rs && byte_x.rw) |=> !(cmd_valid || wr_valid || rd_req)); // R10
endmodule

// File: rtl/lcd_host_port.sv
module lcd_host_port
  import lcd_hbi_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              nib_mode,
  input  logic              hb_e,
  input  logic              hb_rs,
  input  logic              hb_rw,
  input  logic [BYTE_W-1:0] hb_d_in,
  output logic [BYTE_W-1:0] hb_d_out,
  output logic              hb_d_oe,
  input  logic              core_busy,
  input  logic [ADDR_W-1:0] core_addr,
  input  logic              fill_valid,
  input  logic [BYTE_W-1:0] fill_byte,
  output logic              cmd_valid,
  output logic [BYTE_W-1:0] cmd_byte,
  output logic              wr_valid,
  output logic [BYTE_W-1:0] wr_byte,
  output logic              rd_req
);
  hb_xfer_t          bus_raw, cap, byte_x;
  logic              fall, byte_valid, phase;
  logic [BYTE_W-1:0] data_q, rd_word;

  assign bus_raw = '{rs: hb_rs, rw: hb_rw, d: hb_d_in};

  hbi_strobe_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst_n(rst_n), .e_raw(hb_e), .bus_raw(bus_raw),
    .fall(fall), .cap(cap));

  hbi_nibble_pack u_pack (
    .clk(clk), .rst_n(rst_n), .nib_mode(nib_mode), .fall(fall), .cap(cap),
    .byte_valid(byte_valid), .byte_x(byte_x), .phase(phase));

  hbi_core_gate u_gate (
    .clk(clk), .rst_n(rst_n), .byte_valid(byte_valid), .byte_x(byte_x),
    .busy(core_busy), .fill_valid(fill_valid), .fill_byte(fill_byte),
    .data_q(data_q), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req));

  assign rd_word = hb_rs ? data_q : {core_busy, core_addr};
  assign hb_d_oe = hb_e & hb_rw;

  always_comb begin
    if (nib_mode)
      hb_d_out = {(phase ? rd_word[NIB_W-1:0] : rd_word[BYTE_W-1:NIB_W]), {NIB_W{1'b0}}};
    else
      hb_d_out = rd_word;
  end

  AST_NARROW_LOW_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    nib_mode |-> (hb_d_out[NIB_W-1:0] == '0)); // R8
  AST_STATUS_BUSY_BIT: assert property (@(posedge clk) disable iff (!rst_n)
    (!nib_mode && !hb_rs) |-> (hb_d_out[BYTE_W-1] == core_busy)); // R2
endmodule

// File: tb/lcd_host_port_test.sv
module lcd_host_port_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       nib_mode = 1'b0;
  logic       hb_e = 1'b0, hb_rs = 1'b0, hb_rw = 1'b0;
  logic [7:0] hb_d_in = 8'h00;
  logic [7:0] hb_d_out;
  logic       hb_d_oe;
  logic       core_busy = 1'b0;
  logic [6:0] core_addr = 7'h00;
  logic       fill_valid = 1'b0;
  logic [7:0] fill_byte = 8'h00;
  logic       cmd_valid, wr_valid, rd_req;
  logic [7:0] cmd_byte, wr_byte;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  lcd_host_port uut (
    .clk(clk), .rst_n(rst_n), .nib_mode(nib_mode), .hb_e(hb_e), .hb_rs(hb_rs),
    .hb_rw(hb_rw), .hb_d_in(hb_d_in), .hb_d_out(hb_d_out), .hb_d_oe(hb_d_oe),
    .core_busy(core_busy), .core_addr(core_addr), .fill_valid(fill_valid),
    .fill_byte(fill_byte), .cmd_valid(cmd_valid), .cmd_byte(cmd_byte),
    .wr_valid(wr_valid), .wr_byte(wr_byte), .rd_req(rd_req));

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // one bus transfer; rdv = bus value while strobe high,
  // st = {cmd,wr,rd} at the due cycle, extra = any strobe one cycle later
  task automatic xfer(input logic rs, input logic rw, input logic [7:0] d,
                      output logic [7:0] rdv, output logic oe,
                      output logic [2:0] st, output logic extra);
    @(negedge clk);
    hb_rs = rs; hb_rw = rw; hb_d_in = d; hb_e = 1'b1;
    @(negedge clk);
    rdv = hb_d_out; oe = hb_d_oe;
    repeat (2) @(negedge clk);
    hb_e = 1'b0;
    repeat (4) @(negedge clk);
    st = {cmd_valid, wr_valid, rd_req};
    @(negedge clk);
    extra = cmd_valid | wr_valid | rd_req;
  endtask

  task automatic t_reset;
    chk("R9 strobes idle after reset", {cmd_valid, wr_valid, rd_req}, 0);
    chk("R1 oe idle", hb_d_oe, 0);
  endtask

  task automatic t_status;
    logic [7:0] v; logic oe, ex; logic [2:0] st;
    core_addr = 7'h35; core_busy = 1'b0;
    xfer(1'b0, 1'b1, 8'h00, v, oe, st, ex);
    chk("R2 status read", v, 8'h35);
    chk("R1 oe during read", oe, 1);
    chk("R10 status read no strobe", {st, ex}, 0);
    core_busy = 1'b1;
    xfer(1'b0, 1'b1, 8'h00, v, oe, st, ex);
    chk("R10 status while busy", v, 8'hB5);
    chk("R10 no strobe while busy", {st, ex}, 0);
    core_busy = 1'b0;
  endtask

  task automatic t_cmd;
    logic [7:0] v; logic oe, ex; logic [2:0] st;
    xfer(1'b0, 1'b0, 8'h3C, v, oe, st, ex);
    chk("R1 oe during write", oe, 0);
    chk("R4 cmd strobe due", st, 3'b100);
    chk("R4 cmd byte", cmd_byte, 8'h3C);
    chk("R4 cmd single pulse", ex, 0);
  endtask

  task automatic t_data_write;
    logic [7:0] v; logic oe, ex; logic [2:0] st;
    xfer(1'b1, 1'b0, 8'hC3, v, oe, st, ex);
    chk("R5 write strobe due", st, 3'b010);
    chk("R5 write byte", wr_byte, 8'hC3);
    chk("R5 write single pulse", ex, 0);
  endtask

  task automatic t_data_read;
    logic [7:0] v; logic oe, ex; logic [2:0] st;
    xfer(1'b1, 1'b1, 8'h00, v, oe, st, ex);
    chk("R3 data register zero after reset", v, 8'h00);
    @(negedge clk); fill_valid = 1'b1; fill_byte = 8'hA7;
    @(negedge clk); fill_valid = 1'b0; fill_byte = 8'h00;
    xfer(1'b1, 1'b1, 8'h00, v, oe, st, ex);
    chk("R3 prefetched data read", v, 8'hA7);
    chk("R7 read request due", st, 3'b001);
    chk("R7 read request single", ex, 0);
  endtask

  task automatic t_busy;
    logic [7:0] v; logic oe, ex; logic [2:0] st;
    core_busy = 1'b1;
    xfer(1'b0, 1'b0, 8'h01, v, oe, st, ex);
    chk("R6 cmd dropped while busy", {st, ex}, 0);
    xfer(1'b1, 1'b0, 8'h55, v, oe, st, ex);
    chk("R6 data write dropped while busy", {st, ex}, 0);
    xfer(1'b1, 1'b1, 8'h00, v, oe, st, ex);
    chk("R6 data read request dropped while busy", {st, ex}, 0);
    core_busy = 1'b0;
  endtask

  task automatic t_nibble;
    logic [7:0] v; logic oe, ex; logic [2:0] st;
    @(negedge clk); nib_mode = 1'b1;
    repeat (2) @(negedge clk);
    xfer(1'b0, 1'b0, 8'h9F, v, oe, st, ex);
    chk("R8 no strobe after first nibble", {st, ex}, 0);
    xfer(1'b0, 1'b0, 8'h4F, v, oe, st, ex);
    chk("R8 strobe after second nibble", st, 3'b100);
    chk("R8 assembled byte", cmd_byte, 8'h94);
    core_addr = 7'h35;
    xfer(1'b0, 1'b1, 8'h00, v, oe, st, ex);
    chk("R8 status high nibble", v, 8'h30);
    xfer(1'b0, 1'b1, 8'h00, v, oe, st, ex);
    chk("R8 status low nibble", v, 8'h50);
  endtask

  task automatic t_mode_change;
    logic [7:0] v; logic oe, ex; logic [2:0] st;
    xfer(1'b1, 1'b0, 8'hE0, v, oe, st, ex);
    @(negedge clk); nib_mode = 1'b0;
    repeat (2) @(negedge clk);
    @(negedge clk); nib_mode = 1'b1;
    repeat (2) @(negedge clk);
    xfer(1'b1, 1'b0, 8'h20, v, oe, st, ex);
    chk("R9 phase rearmed, first nibble held", {st, ex}, 0);
    xfer(1'b1, 1'b0, 8'h70, v, oe, st, ex);
    chk("R9 byte from fresh pair", wr_byte, 8'h27);
    chk("R9 write strobe after pair", st, 3'b010);
    @(negedge clk); nib_mode = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_status();
    t_cmd();
    t_data_write();
    t_data_read();
    t_busy();
    t_nibble();
    t_mode_change();
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule